// File: doc/BRIEF.md
# Single-Cycle Main Control Decoder

This block is the main control unit of a 32-bit single-cycle load/store processor. It looks only at the 6-bit opcode field of the instruction being executed and, in the same cycle and with no storage of its own, produces every control point the datapath needs. These are the destination register select, the ALU second-operand select, the writeback source select, the register-file and data-memory write enables, the branch and jump selects, the immediate-extension mode, and a 3-bit operation class for a separate ALU control decoder.

R-type instructions share a single opcode. For them the operation class tells the downstream ALU decoder to take the operation from the function field, which this block never sees. The decoder is laid out as an AND plane and an OR plane. One match term per supported opcode selects a stored control word, and the selected words are OR-ed together. An opcode that matches no term therefore yields an all-zero word, which leaves architectural state unchanged.

Top module: `ctrl_decoder`

## Requirements
- R1: Opcode 000000 (R-type) gives reg_dst=1, alu_src=0, mem_to_reg=0, reg_wr=1, mem_wr=0, branch=0, jump=0, ext_sign=0 and alu_op=100, which means "use the function field".
- R2: Opcode 001101 (or-immediate) gives reg_dst=0, alu_src=1, mem_to_reg=0, reg_wr=1, mem_wr=0, branch=0, jump=0, ext_sign=0 (zero extension) and alu_op=010 (OR).
- R3: Opcode 100011 (load word) gives reg_dst=0, alu_src=1, mem_to_reg=1, reg_wr=1, mem_wr=0, branch=0, jump=0, ext_sign=1 (sign extension) and alu_op=000 (add).
- R4: Opcode 101011 (store word) gives mem_wr=1, reg_wr=0, alu_src=1, ext_sign=1, branch=0, jump=0 and alu_op=000. reg_dst and mem_to_reg are 0.
- R5: Opcode 000100 (branch-if-equal) gives branch=1, jump=0, alu_src=0, ext_sign=1, reg_wr=0, mem_wr=0 and alu_op=001 (subtract). reg_dst and mem_to_reg are 0.
- R6: Opcode 000010 (jump) gives jump=1 and every other output 0, including alu_op=000.
- R7: Any other opcode drives all outputs to 0.
- R8: reg_wr is 1 exactly when the opcode is 000000, 001101 or 100011.
- R9: At most one of reg_wr, mem_wr, branch and jump is 1 for any opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 6 | Opcode field of the current instruction |
| reg_dst_o | output | 1 | 1 selects the rd field as write register, 0 selects rt |
| alu_src_o | output | 1 | 1 selects the extended immediate as ALU operand B |
| mem_to_reg_o | output | 1 | 1 writes data-memory read data back, 0 writes the ALU result |
| reg_wr_o | output | 1 | Register file write enable |
| mem_wr_o | output | 1 | Data memory write enable |
| branch_o | output | 1 | Conditional branch select for next-address logic |
| jump_o | output | 1 | Jump select for next-address logic |
| ext_sign_o | output | 1 | 1 sign-extends the 16-bit immediate, 0 zero-extends it |
| alu_op_o | output | 3 | Operation class for the ALU control decoder |

## Verification
The corner that is hardest to reach is an opcode that differs from a supported one by a single bit. A decoder that ignores one bit would alias it onto a real instruction and assert a write enable. A few hand-picked opcodes would not reach every such neighbour. The bench therefore first walks a table of the six supported vectors. It then sweeps all 64 opcode values against a model written from the requirements, so that every near-miss opcode is checked for an all-quiet control word.

// File: rtl/ctrl_decoder_pkg.sv
// Package: shared widths, opcode list and the per-instruction control word.
// Assumes the opcode is the 6-bit primary field and R-type ops share one code.
package ctrl_decoder_pkg;

    localparam int OPC_W   = 6;
    localparam int ALUOP_W = 3;
    localparam int N_INSN  = 6;

    // Operation classes understood by the ALU control decoder.
    localparam logic [ALUOP_W-1:0] ALUOP_ADD  = 3'b000;
    localparam logic [ALUOP_W-1:0] ALUOP_SUB  = 3'b001;
    localparam logic [ALUOP_W-1:0] ALUOP_OR   = 3'b010;
    localparam logic [ALUOP_W-1:0] ALUOP_FUNC = 3'b100;

    typedef struct packed {
        logic               reg_dst;
        logic               alu_src;
        logic               mem_to_reg;
        logic               reg_wr;
        logic               mem_wr;
        logic               branch;
        logic               jump;
        logic               ext_sign;
        logic [ALUOP_W-1:0] alu_op;
    } ctrl_word_t;

    localparam int CW_W = $bits(ctrl_word_t);

    // Opcode of each supported instruction, one match term each.
    localparam logic [OPC_W-1:0] OPC_LIST [N_INSN] = '{
        6'b000000,   // register-register arithmetic
        6'b001101,   // or with zero-extended immediate
        6'b100011,   // load word
        6'b101011,   // store word
        6'b000100,   // branch if equal
        6'b000010    // jump
    };

    // Control word selected by each match term; don't-cares are held at 0.
    localparam ctrl_word_t CW_LIST [N_INSN] = '{
        '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, ALUOP_FUNC},
        '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, ALUOP_OR},
        '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, ALUOP_ADD},
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, ALUOP_ADD},
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, ALUOP_SUB},
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, ALUOP_ADD}
    };

endpackage

// File: rtl/opcode_match.sv
// Module: opcode_match
// AND plane of the decoder: one full-width equality term per supported
// opcode. Assumes the opcode list in the package holds distinct values,
// so at most one bit of hit_o is set.
module opcode_match
    import ctrl_decoder_pkg::*;
#(
    parameter int W_OPC = OPC_W,
    parameter int N     = N_INSN
) (
    input  logic [W_OPC-1:0] opcode_i,
    output logic [N-1:0]     hit_o
);

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_term
            // One product term compares every opcode bit.
            assign hit_o[g] = (opcode_i == OPC_LIST[g]);
        end
    endgenerate

endmodule

// File: rtl/ctrl_word_or.sv
// Module: ctrl_word_or
// OR plane of the decoder: each active match term contributes its stored
// control word. Assumes at most one term is active; with none active the
// output word is all zero, which keeps architectural state unchanged.
module ctrl_word_or
    import ctrl_decoder_pkg::*;
#(
    parameter int N = N_INSN
) (
    input  logic [N-1:0] hit_i,
    output ctrl_word_t   word_o
);

    // Sum of the selected control words.
    always_comb begin
        word_o = '0;
        for (int i = 0; i < N; i++) begin
            word_o = word_o | (hit_i[i] ? CW_LIST[i] : ctrl_word_t'('0));
        end
    end

endmodule

// File: rtl/ctrl_decoder.sv
// Module: ctrl_decoder
// Main control unit of a single-cycle processor: maps the opcode to every
// datapath control point with no state and no clock. The function field is
// left to a separate ALU decoder, signalled by the "use function" class.
module ctrl_decoder
    import ctrl_decoder_pkg::*;
(
    input  logic [5:0] opcode_i,
    output logic       reg_dst_o,
    output logic       alu_src_o,
    output logic       mem_to_reg_o,
    output logic       reg_wr_o,
    output logic       mem_wr_o,
    output logic       branch_o,
    output logic       jump_o,
    output logic       ext_sign_o,
    output logic [2:0] alu_op_o
);

    logic [N_INSN-1:0] hit;
    ctrl_word_t        word;

    opcode_match #(.W_OPC(OPC_W), .N(N_INSN)) u_match (
        .opcode_i (opcode_i),
        .hit_o    (hit)
    );

    ctrl_word_or #(.N(N_INSN)) u_or (
        .hit_i  (hit),
        .word_o (word)
    );

    // Unpack the selected control word onto the ports.
    always_comb begin
        reg_dst_o    = word.reg_dst;
        alu_src_o    = word.alu_src;
        mem_to_reg_o = word.mem_to_reg;
        reg_wr_o     = word.reg_wr;
        mem_wr_o     = word.mem_wr;
        branch_o     = word.branch;
        jump_o       = word.jump;
        ext_sign_o   = word.ext_sign;
        alu_op_o     = word.alu_op;
    end

endmodule

// File: rtl/ctrl_decoder_chk.sv
// Module: ctrl_decoder_chk
// Port-level checker for ctrl_decoder, attached by bind. The block has no
// clock, so the checks are immediate and skip any cycle with an unknown opcode.
module ctrl_decoder_chk (
    input logic [5:0] opcode_i,
    input logic       reg_dst_o,
    input logic       alu_src_o,
    input logic       mem_to_reg_o,
    input logic       reg_wr_o,
    input logic       mem_wr_o,
    input logic       branch_o,
    input logic       jump_o,
    input logic       ext_sign_o,
    input logic [2:0] alu_op_o
);

    logic known;
    logic supported;

    // Qualify checks and classify the opcode independently of the decoder.
    always_comb begin
        known     = !$isunknown(opcode_i);
        supported = (opcode_i == 6'd0)  || (opcode_i == 6'd13) ||
                    (opcode_i == 6'd35) || (opcode_i == 6'd43) ||
                    (opcode_i == 6'd4)  || (opcode_i == 6'd2);
    end

    // Port relations that must hold for every settled opcode.
    always_comb begin
        if (known) begin
            // R8
            regwr_src_chk: assert (reg_wr_o ==
                ((opcode_i == 6'd0) || (opcode_i == 6'd13) || (opcode_i == 6'd35)));
            // R9
            one_effect_chk: assert ($countones({reg_wr_o, mem_wr_o, branch_o, jump_o}) <= 1);
            // R7
            unknown_quiet_chk: assert (supported ||
                ({reg_dst_o, alu_src_o, mem_to_reg_o, reg_wr_o, mem_wr_o,
                  branch_o, jump_o, ext_sign_o, alu_op_o} == 11'd0));
            // R3
            load_path_chk: assert (!mem_to_reg_o || (reg_wr_o && alu_src_o && ext_sign_o));
            // R5
            branch_sub_chk: assert (!branch_o || (alu_op_o == 3'b001 && !alu_src_o));
        end
    end

endmodule

bind ctrl_decoder ctrl_decoder_chk u_ctrl_decoder_chk (
    .opcode_i     (opcode_i),
    .reg_dst_o    (reg_dst_o),
    .alu_src_o    (alu_src_o),
    .mem_to_reg_o (mem_to_reg_o),
    .reg_wr_o     (reg_wr_o),
    .mem_wr_o     (mem_wr_o),
    .branch_o     (branch_o),
    .jump_o       (jump_o),
    .ext_sign_o   (ext_sign_o),
    .alu_op_o     (alu_op_o)
);

// File: tb/ctrl_decoder_bench.sv
// Bench for ctrl_decoder: a vector table for the supported opcodes, then a
// sweep of all 64 opcodes against a model written from the requirements.
module ctrl_decoder_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N_VEC      = 6;

    // {opcode, reg_dst, alu_src, mem_to_reg, reg_wr, mem_wr, branch, jump, ext_sign, alu_op}
    localparam logic [16:0] VEC [N_VEC] = '{
        {6'b000000, 8'b1001_0000, 3'b100},   // R1
        {6'b001101, 8'b0101_0000, 3'b010},   // R2
        {6'b100011, 8'b0111_0001, 3'b000},   // R3
        {6'b101011, 8'b0100_1001, 3'b000},   // R4
        {6'b000100, 8'b0000_0101, 3'b001},   // R5
        {6'b000010, 8'b0000_0010, 3'b000}    // R6
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] opcode;
    logic       reg_dst, alu_src, mem_to_reg, reg_wr, mem_wr, branch, jump, ext_sign;
    logic [2:0] alu_op;
    int         checks = 0;
    int         errors = 0;
    logic       done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctrl_decoder u_ctrl_decoder (
        .opcode_i     (opcode),
        .reg_dst_o    (reg_dst),
        .alu_src_o    (alu_src),
        .mem_to_reg_o (mem_to_reg),
        .reg_wr_o     (reg_wr),
        .mem_wr_o     (mem_wr),
        .branch_o     (branch),
        .jump_o       (jump),
        .ext_sign_o   (ext_sign),
        .alu_op_o     (alu_op)
    );

    function automatic logic [10:0] model(input logic [5:0] op);
        case (op)
            6'b000000: return {8'b1001_0000, 3'b100};
            6'b001101: return {8'b0101_0000, 3'b010};
            6'b100011: return {8'b0111_0001, 3'b000};
            6'b101011: return {8'b0100_1001, 3'b000};
            6'b000100: return {8'b0000_0101, 3'b001};
            6'b000010: return {8'b0000_0010, 3'b000};
            default:   return 11'd0;   // R7
        endcase
    endfunction

    task automatic apply_check(input logic [5:0] op, input logic [10:0] exp, input string req);
        logic [10:0] act;
        @(posedge clk);
        opcode = op;
        @(negedge clk);
        act = {reg_dst, alu_src, mem_to_reg, reg_wr, mem_wr, branch, jump, ext_sign, alu_op};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s opcode=%b actual=%b expected=%b", req, op, act, exp);
        end
    endtask

    initial begin
        opcode = 6'b000000;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // State right after the bench reset: opcode 0 decodes as R-type (R1).
        apply_check(6'b000000, {8'b1001_0000, 3'b100}, "R1");
        for (int i = 0; i < N_VEC; i++) begin
            apply_check(VEC[i][16:11], VEC[i][10:0], $sformatf("R%0d", i + 1));
        end
        // Full sweep: supported codes, one-bit neighbours and the rest (R7).
        for (int op = 0; op < 64; op++) begin
            apply_check(6'(op), model(6'(op)), "R7");
            checks++;   // R8: write enable follows the three writing opcodes
            if (reg_wr !== (op == 0 || op == 13 || op == 35)) begin
                errors++;
                $display("FAIL R8 opcode=%0d actual=%b expected=%b", op, reg_wr,
                         (op == 0 || op == 13 || op == 35));
            end
            checks++;   // R9: one state-changing effect at most
            if ($countones({reg_wr, mem_wr, branch, jump}) > 1) begin
                errors++;
                $display("FAIL R9 opcode=%0d actual=%b expected=<=1 set", op,
                         {reg_wr, mem_wr, branch, jump});
            end
        end
        // Corner opcodes: all ones, and one bit away from store and jump.
        apply_check(6'b111111, 11'd0, "R7");
        apply_check(6'b101010, 11'd0, "R7");
        apply_check(6'b000011, 11'd0, "R7");
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule